// File: doc/BRIEF.md
# Debug Register Access Controller

This block is an auxiliary debug port that runs its own IEEE 1149.1 TAP state machine once an upstream chip-level controller hands it the scan pins. Its instructions are decoded from the IR path. One of them, the register-access enable instruction, opens a small access machine with three states: idle, register select and data access. A first DR scan in register select names an internal register by its index and says whether the access is a read or a write. A second DR scan of 32 bits moves the data. It either captures the register for TDO or writes it at Update-DR.

There is no IDCODE instruction. The device identity is read as an ordinary register (index 0). It is also sent as a message on a 4-bit parallel output when the port control register (index 1) is written with its output-enable bit set. The message is a 6-bit transfer code followed by the 32-bit device ID, sent LSB first one nibble per TCK, with a start strobe on the first nibble.

Top module: `dbg_access_port`

## Requirements
- R1: The whole block resets asynchronously while `por_n` is low or `comp_en` is low: TAP in Test-Logic-Reset, access machine idle, port control register 0, `mdo` 0 and `msg_start` 0.
- R2: While `aux_sel` is low the TAP and access machine hold their state regardless of `tms`/`tdi`, and `tdo` is 0.
- R3: Capture-IR loads the IR shifter with binary 0001, which shifts out on `tdo` LSB first during Shift-IR.
- R4: An IR value equal to `ENA_INSN` (default 4'hC) at Update-IR puts the access machine in register select, where the DR path is 8 bits long and captures 0.
- R5: In register select, the 8-bit DR holds the register index in bits 6:0 and the write flag in bit 7 (1 = write). Update-DR moves to data access, where the DR is 32 bits. The next Update-DR returns to register select.
- R6: A read of index 0 shifts out the `DEV_ID` parameter on `tdo`, LSB first, from the 32-bit data scan.
- R7: Any other IR value at Update-IR sends the access machine to idle, where the DR path is a 1-bit bypass that captures 0.
- R8: Index 1 is a 32-bit read/write port control register. Writes to index 0 or to any other index have no effect, and reads of indices 2 to 127 return 0.
- R9: A write to index 1 with bit 0 set makes `msg_start` high for one cycle on the TCK after the Update-DR exit. During that cycle and the nine after it, `mdo` carries {2'b00, DEV_ID, TCODE} one nibble at a time, low nibble first. Outside a message `mdo` is 0. A write with bit 0 clear sends nothing.
- R10: Entering Test-Logic-Reset (five TCKs with `tms` high) returns the access machine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low |
| comp_en | input | 1 | Compliance enable; low holds the block in reset |
| aux_sel | input | 1 | TAP ownership granted by the upstream controller |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| mdo | output | 4 | Parallel message nibble |
| msg_start | output | 1 | Strobe on the first nibble of a message |

## Verification
All 16 IR values are loaded. Each is followed by a 16-bit probe scan, and the bit offset of the probe's echo on `tdo` gives the DR length, and so tells idle apart from register select. Every one of the 128 register indices is written with a distinct pattern and then read back. This separates the read-only ID, the writable control register and the unmapped space. Control-register writes with bit 0 set and with it clear show whether a message starts, and a parallel monitor reassembles the nibbles. Ownership withdrawal, compliance reset and Test-Logic-Reset are each followed by a length probe that shows whether the access state survived.

// File: rtl/dbg_access_port.sv
module dbg_access_port #(
  parameter int DATA_W = 32,
  parameter int IDX_W = 7,
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] ENA_INSN = 'hC,
  parameter logic [31:0] DEV_ID = 32'h4B7D_2C19,
  parameter int TCODE_W = 6,
  parameter logic [TCODE_W-1:0] TCODE = 6'h21,
  parameter int MDO_W = 4
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             comp_en,
  input  logic             aux_sel,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic [MDO_W-1:0] mdo,
  output logic             msg_start
);
  localparam int SEL_W = IDX_W + 1;
  localparam int MSG_BITS = TCODE_W + DATA_W;
  localparam int NIBS = (MSG_BITS + MDO_W - 1) / MDO_W;
  localparam int MSG_W = NIBS * MDO_W;
  localparam int CNT_W = $clog2(NIBS + 1);
  localparam int TOP_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_ID = 0;
  localparam logic [IDX_W-1:0] IDX_PCR = 1;

  localparam logic [3:0] TLR = 0, RTI = 1, SELDR = 2, CAPDR = 3, SHDR = 4, EX1DR = 5,
    PADR = 6, EX2DR = 7, UPDR = 8, SELIR = 9, CAPIR = 10, SHIR = 11, EX1IR = 12,
    PAIR = 13, EX2IR = 14, UPIR = 15;
  localparam logic [1:0] A_IDLE = 0, A_RSEL = 1, A_DACC = 2;

  wire rst_n = por_n & comp_en;

  logic [3:0] tap, tap_nx;
  logic [1:0] acc;
  logic [IR_W-1:0] ir_sh;
  logic [DATA_W-1:0] dr_sh, dr_shift, pcr, rd_val;
  logic [IDX_W-1:0] idx;
  logic wr;
  logic [TOP_W-1:0] dr_top;
  logic [MSG_W-1:0] msg_sh;
  logic [CNT_W-1:0] msg_left;
  logic msg_first;

  always_comb begin
    case (tap)
      TLR:   tap_nx = tms ? TLR   : RTI;
      RTI:   tap_nx = tms ? SELDR : RTI;
      SELDR: tap_nx = tms ? SELIR : CAPDR;
      CAPDR: tap_nx = tms ? EX1DR : SHDR;
      SHDR:  tap_nx = tms ? EX1DR : SHDR;
      EX1DR: tap_nx = tms ? UPDR  : PADR;
      PADR:  tap_nx = tms ? EX2DR : PADR;
      EX2DR: tap_nx = tms ? UPDR  : SHDR;
      UPDR:  tap_nx = tms ? SELDR : RTI;
      SELIR: tap_nx = tms ? TLR   : CAPIR;
      CAPIR: tap_nx = tms ? EX1IR : SHIR;
      SHIR:  tap_nx = tms ? EX1IR : SHIR;
      EX1IR: tap_nx = tms ? UPIR  : PAIR;
      PAIR:  tap_nx = tms ? EX2IR : PAIR;
      EX2IR: tap_nx = tms ? UPIR  : SHIR;
      default: tap_nx = tms ? SELDR : RTI;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) tap <= TLR;
    else if (aux_sel) tap <= tap_nx;

  assign dr_top = (acc == A_DACC) ? TOP_W'(DATA_W - 1) :
                  (acc == A_RSEL) ? TOP_W'(SEL_W - 1) : '0;

  always_comb begin
    dr_shift = dr_sh >> 1;
    dr_shift[dr_top] = tdi;
  end

  always_comb begin
    case (idx)
      IDX_ID:  rd_val = DEV_ID;
      IDX_PCR: rd_val = pcr;
      default: rd_val = '0;
    endcase
  end

  wire pcr_wr = aux_sel && tap == UPDR && acc == A_DACC && wr && idx == IDX_PCR;
  wire msg_go = pcr_wr && dr_sh[0];

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      acc <= A_IDLE;
      ir_sh <= '0;
      dr_sh <= '0;
      idx <= '0;
      wr <= 1'b0;
      pcr <= '0;
    end else if (aux_sel) begin
      case (tap)
        TLR:   acc <= A_IDLE;
        CAPIR: ir_sh <= IR_W'(1);
        SHIR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        UPIR:  acc <= (ir_sh == ENA_INSN) ? A_RSEL : A_IDLE;
        CAPDR: dr_sh <= (acc == A_DACC && !wr) ? rd_val : '0;
        SHDR:  dr_sh <= dr_shift;
        UPDR: begin
          if (acc == A_RSEL) begin
            idx <= dr_sh[IDX_W-1:0];
            wr <= dr_sh[IDX_W];
            acc <= A_DACC;
          end else if (acc == A_DACC) begin
            if (pcr_wr) pcr <= dr_sh;
            acc <= A_RSEL;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      msg_sh <= '0;
      msg_left <= '0;
      msg_first <= 1'b0;
    end else if (msg_go) begin
      msg_sh <= MSG_W'({DEV_ID, TCODE});
      msg_left <= CNT_W'(NIBS);
      msg_first <= 1'b1;
    end else if (msg_left != 0) begin
      msg_sh <= msg_sh >> MDO_W;
      msg_left <= msg_left - 1'b1;
      msg_first <= 1'b0;
    end
  end

  assign mdo = (msg_left != 0) ? msg_sh[MDO_W-1:0] : '0;
  assign msg_start = msg_first;
  assign tdo = aux_sel & ((tap == SHDR) ? dr_sh[0] : (tap == SHIR) ? ir_sh[0] : 1'b0);
endmodule

// File: rtl/dbg_access_port_chk.sv
module dbg_access_port_chk #(
  parameter int IDX_W = 7,
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] ENA_INSN = 'hC,
  parameter int MDO_W = 4
) (
  input logic             tck,
  input logic             por_n,
  input logic             comp_en,
  input logic             aux_sel,
  input logic [3:0]       tap,
  input logic [1:0]       acc,
  input logic [IR_W-1:0]  ir_sh,
  input logic             dr_lsb,
  input logic             wr,
  input logic [IDX_W-1:0] idx,
  input logic [MDO_W-1:0] mdo,
  input logic             msg_start
);
  localparam logic [3:0] TLR = 0, UPDR = 8, UPIR = 15;
  localparam logic [1:0] A_IDLE = 0, A_RSEL = 1, A_DACC = 2;
  wire rstn = por_n && comp_en;

  a_r1_quiet_in_reset: assert property (@(posedge tck) disable iff (!por_n)
    !comp_en |-> (mdo == '0 && !msg_start));
  a_r2_hold_without_owner: assert property (@(posedge tck) disable iff (!rstn)
    !aux_sel |=> ($stable(tap) && $stable(acc)));
  a_r4_enable_selects: assert property (@(posedge tck) disable iff (!rstn)
    (aux_sel && tap == UPIR && ir_sh == ENA_INSN) |=> acc == A_RSEL);
  a_r7_other_idles: assert property (@(posedge tck) disable iff (!rstn)
    (aux_sel && tap == UPIR && ir_sh != ENA_INSN) |=> acc == A_IDLE);
  a_r5_no_skip_select: assert property (@(posedge tck) disable iff (!rstn)
    (acc == A_IDLE) |=> acc != A_DACC);
  a_r10_tlr_idles: assert property (@(posedge tck) disable iff (!rstn)
    (aux_sel && tap == TLR) |=> acc == A_IDLE);
  a_r9_start_after_write: assert property (@(posedge tck) disable iff (!rstn)
    (aux_sel && tap == UPDR && acc == A_DACC && wr && idx == IDX_W'(1) && dr_lsb) |=> msg_start);
  a_r9_single_strobe: assert property (@(posedge tck) disable iff (!rstn)
    msg_start |=> !msg_start);
endmodule

bind dbg_access_port dbg_access_port_chk #(
  .IDX_W(IDX_W), .IR_W(IR_W), .ENA_INSN(ENA_INSN), .MDO_W(MDO_W)
) u_chk (
  .tck(tck), .por_n(por_n), .comp_en(comp_en), .aux_sel(aux_sel),
  .tap(tap), .acc(acc), .ir_sh(ir_sh), .dr_lsb(dr_sh[0]), .wr(wr), .idx(idx),
  .mdo(mdo), .msg_start(msg_start)
);

// File: tb/sim_dbg_access_port.sv
`timescale 1ns/1ps
module sim_dbg_access_port;
  localparam logic [31:0] DEV = 32'h4B7D_2C19;
  localparam logic [5:0] TC = 6'h21;
  localparam logic [3:0] ENA = 4'hC;
  localparam logic [39:0] MSG = {2'b00, DEV, TC};
  localparam int NIBS = 10;

  logic tck = 0, por_n = 0, comp_en = 0, aux_sel = 0, tms = 1, tdi = 0;
  logic tdo, msg_start;
  logic [3:0] mdo;
  int checks = 0, fails = 0, cycles = 0;
  int msgs = 0, idle_bad = 0, k = NIBS;
  logic [39:0] rx;
  logic mon_en = 0;
  logic [31:0] pcr_exp;

  always #2 tck = ~tck;

  dbg_access_port #(.DEV_ID(DEV), .TCODE(TC), .ENA_INSN(ENA)) u0 (
    .tck(tck), .por_n(por_n), .comp_en(comp_en), .aux_sel(aux_sel),
    .tms(tms), .tdi(tdi), .tdo(tdo), .mdo(mdo), .msg_start(msg_start));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    o = tdo;
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck);
  endtask

  task automatic load_ir(input logic [3:0] v, output logic [3:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 4; i++) begin step(i == 3, v[i], o); cap[i] = o; end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic o;
    dout = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < n; i++) begin step(i == n - 1, din[i], o); dout[i] = o; end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic probe(input int len, input string tag);
    logic [31:0] o;
    logic [15:0] pin = 16'h05A6;
    logic [15:0] e = pin << len;
    scan_dr(16, {16'h0, pin}, o);
    chk(o[15:0] == e, tag, o[15:0], e);
    if (len == 8) begin
      scan_dr(32, 32'hFFFF_FFFF, o);
      chk(o == 0, "R8 unmapped index 5 reads 0", o, 0);
    end
  endtask

  task automatic sel(input logic w, input logic [6:0] ix);
    logic [31:0] o;
    scan_dr(8, {24'h0, w, ix}, o);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(negedge tck) begin
    cycles++;
    if (mon_en) begin
      if (msg_start) begin k = 0; msgs++; rx = '0; end
      if (k < NIBS) begin
        rx[4*k +: 4] = mdo;
        k++;
        if (k == NIBS) chk(rx == MSG, "R9 message content", rx, MSG);
      end else if (mdo != 0) idle_bad++;
    end
  end

  initial begin
    wait (cycles > 150000);
    chk(0, "watchdog expired", cycles, 150000);
    finish_run();
  end

  initial begin
    logic [3:0] cap;
    logic [31:0] o, pat;
    logic x;
    repeat (3) @(negedge tck);
    chk(tdo == 0 && mdo == 0 && msg_start == 0, "R1 outputs in reset", {tdo, mdo, msg_start}, 0);
    por_n = 1; comp_en = 1; aux_sel = 1; mon_en = 1;
    step(0, 0, x);
    probe(1, "R1 bypass after power-on");

    for (int v = 0; v < 16; v++) begin
      load_ir(4'(v), cap);
      chk(cap == 4'b0001, "R3 IR capture", cap, 4'b0001);
      if (4'(v) == ENA) probe(8, "R4 select length after enable");
      else probe(1, "R7 bypass after other instruction");
    end

    load_ir(ENA, cap);
    pcr_exp = '0;
    for (int ix = 0; ix < 128; ix++) begin
      pat = (32'h9E37_79B9 * 32'(ix + 1)) & ~32'h1;
      sel(1, 7'(ix));
      scan_dr(32, pat, o);
      if (ix == 1) pcr_exp = pat;
      sel(0, 7'(ix));
      scan_dr(32, 32'h0, o);
      if (ix == 0) chk(o == DEV, "R6 device ID read, R8 write to ID ignored", o, DEV);
      else if (ix == 1) chk(o == pcr_exp, "R8 control register read back", o, pcr_exp);
      else chk(o == 0, "R8 unmapped read", o, 0);
    end
    probe(8, "R5 back in select after data access");

    sel(1, 7'd1);
    scan_dr(32, 32'hC0DE_0001, o);
    chk(msg_start == 1, "R9 strobe after control write", msg_start, 1);
    repeat (12) @(negedge tck);
    chk(msgs == 1, "R9 one message sent", msgs, 1);
    sel(1, 7'd1);
    scan_dr(32, 32'h1234_5670, o);
    chk(msg_start == 0, "R9 no strobe when bit 0 clear", msg_start, 0);
    repeat (12) @(negedge tck);
    chk(msgs == 1, "R9 no message when bit 0 clear", msgs, 1);
    chk(idle_bad == 0, "R9 mdo low when idle", idle_bad, 0);

    aux_sel = 0;
    tms = 1; tdi = 1;
    for (int i = 0; i < 8; i++) begin
      @(posedge tck); @(negedge tck);
      tms = (i % 3) == 0; tdi = ~tdi;
      if (tdo != 0) idle_bad++;
    end
    chk(idle_bad == 0, "R2 tdo low without ownership", idle_bad, 0);
    aux_sel = 1; tms = 0;
    probe(8, "R2 state held without ownership");

    for (int i = 0; i < 5; i++) step(1, 0, x);
    step(0, 0, x);
    probe(1, "R10 idle after test-logic-reset");

    load_ir(ENA, cap);
    comp_en = 0;
    repeat (3) @(negedge tck);
    chk(tdo == 0 && mdo == 0, "R1 outputs while comp_en low", {tdo, mdo}, 0);
    comp_en = 1;
    step(0, 0, x);
    probe(1, "R1 idle after comp_en reset");
    load_ir(ENA, cap);
    sel(0, 7'd1);
    scan_dr(32, 32'h0, o);
    chk(o == 0, "R1 control register cleared", o, 0);

    finish_run();
  end
endmodule